// File: doc/BRIEF.md
# Two-Level Device Address Translation Walker

This block turns a 32-bit device address into a physical address. It walks a two-level page table held in memory. A client presents an address on a request/ready handshake. The walker then fetches one first-level descriptor through a simple memory read port and, when needed, one second-level descriptor. After the last read it reports a single-cycle completion that carries either the physical address and the page-size code, or a fault.

The first-level table holds one word for each 1 MB of device address space, and its base is supplied on a port. A first-level word either maps a 1 MB region or a 16 MB region directly, or points to a second-level table of 256 words. A second-level word maps 4 KB or 64 KB. A 16 MB mapping and a 64 KB mapping each occupy 16 consecutive identical words, so the walk lands on whichever copy the address selects. The result keeps the frame bits of the descriptor above the page size and takes the bits below it from the device address.

Top module: `iopt_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: The cycle after a request is accepted, `mem_rd_en` pulses with address {tbl_base[31:14], va[31:20], 2'b00}.
- R3: A first-level word with bits 1:0 = 2'b10 and bit 18 clear is a 1 MB leaf: pa = {desc[31:20], va[19:0]}, size code 2, no second read.
- R4: A first-level word with bits 1:0 = 2'b10 and bit 18 set is a 16 MB leaf: pa = {desc[31:24], va[23:0]}, size code 3. Each of its 16 replicated words translates the same way.
- R5: A first-level word with bits 1:0 = 2'b01 points to a second-level table. The cycle after its read data arrives, a second read is issued at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level word with bit 1 set (bits 1:0 = 2'b1x) is a 4 KB page: pa = {desc[31:12], va[11:0]}, size code 0.
- R7: A second-level word with bits 1:0 = 2'b01 is a 64 KB page: pa = {desc[31:16], va[15:0]}, size code 1. Each of its 16 replicated words translates the same way.
- R8: A first-level word with bits 1:0 of 2'b00 or 2'b11, or a second-level word with bits 1:0 = 2'b00 (any all-zero word included), completes with `done_fault` = 1, `done_pa` = 0 and `done_size` = 0.
- R9: Every translation issues one or two reads, each a one-cycle `mem_rd_en` pulse, with never more than one read outstanding. Read data is taken on `mem_rd_valid`, which arrives at least one cycle after the request.
- R10: `req_ready` falls the cycle after an acceptance and stays low until the cycle after `done`. `req_valid` and `req_va` driven while busy are ignored.
- R11: `done` is a one-cycle pulse, raised the cycle after the final read data arrives. `req_ready` returns the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 32 | Device address to translate |
| tbl_base | input | 32 | First-level table base, 16 KB aligned |
| mem_rd_en | output | 1 | Descriptor read request pulse |
| mem_rd_addr | output | 32 | Descriptor word address (byte address) |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor word returned |
| done | output | 1 | Translation complete, one cycle |
| done_pa | output | 32 | Physical address (0 on fault) |
| done_size | output | 2 | Page size code: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| done_fault | output | 1 | Translation fault |

## Verification
Several rules are checked by assertions on every cycle. These include the placement of the first-level and second-level read addresses, the one-cycle read pulse and the limit of two reads per walk. They also cover the drop of ready after acceptance, the single-cycle done, the zero result on a fault, and the pass-through of the low 12 address bits on any leaf. Other behaviour can only be shown by the bench's scenarios. That covers the actual frame bits chosen for each of the four page sizes, the equal result from the first and last replicated copy of a 16 MB or 64 KB mapping, and the split between fault codes and the reserved first-level type. It also covers requests driven while busy being ignored and varying memory latency. The bench checks these against a behavioural model compared on every clock.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_64K = 2'd1,
      PG_1M  = 2'd2,
      PG_16M = 2'd3
   } pg_size_e;

   typedef enum logic [1:0] {
      L1_NONE  = 2'b00,
      L1_TABLE = 2'b01,
      L1_BLOCK = 2'b10,
      L1_RSVD  = 2'b11
   } l1_kind_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_WAIT1 = 2'd1,
      S_WAIT2 = 2'd2,
      S_RESP  = 2'd3
   } walk_state_e;

endpackage

// File: rtl/iopt_l1_decode.sv
module iopt_l1_decode
   import iopt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int L2_IDX_W  = 8,
   parameter int SMALL_SH  = 12,
   parameter int SECT_SH   = 20,
   parameter int SUPER_SH  = 24,
   parameter int SUPER_BIT = 18
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output logic              is_table,
   output logic              leaf_fault,
   output logic [ADDR_W-1:0] leaf_pa,
   output pg_size_e          leaf_size,
   output logic [ADDR_W-1:0] l2_addr
);
   localparam int L2_ALIGN = L2_IDX_W + 2;

   l1_kind_e kind;

   always_comb begin
      kind       = l1_kind_e'(desc[1:0]);
      is_table   = (kind == L1_TABLE);
      leaf_fault = 1'b1;
      leaf_pa    = '0;
      leaf_size  = PG_4K;
      if (kind == L1_BLOCK) begin
         leaf_fault = 1'b0;
         if (desc[SUPER_BIT]) begin
            leaf_size = PG_16M;
            leaf_pa   = {desc[ADDR_W-1:SUPER_SH], va[SUPER_SH-1:0]};
         end else begin
            leaf_size = PG_1M;
            leaf_pa   = {desc[ADDR_W-1:SECT_SH], va[SECT_SH-1:0]};
         end
      end
      l2_addr = {desc[ADDR_W-1:L2_ALIGN], va[SECT_SH-1:SMALL_SH], 2'b00};
   end

endmodule

// File: rtl/iopt_l2_decode.sv
module iopt_l2_decode
   import iopt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SMALL_SH = 12,
   parameter int LARGE_SH = 16
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output logic              leaf_fault,
   output logic [ADDR_W-1:0] leaf_pa,
   output pg_size_e          leaf_size
);
   always_comb begin
      leaf_fault = 1'b0;
      leaf_pa    = '0;
      leaf_size  = PG_4K;
      if (desc[1]) begin
         leaf_pa = {desc[ADDR_W-1:SMALL_SH], va[SMALL_SH-1:0]};
      end else if (desc[0]) begin
         leaf_size = PG_64K;
         leaf_pa   = {desc[ADDR_W-1:LARGE_SH], va[LARGE_SH-1:0]};
      end else begin
         leaf_fault = 1'b1;
      end
   end

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
   import iopt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int L1_IDX_W  = 12,
   parameter int L2_IDX_W  = 8,
   parameter int SMALL_SH  = 12,
   parameter int LARGE_SH  = 16,
   parameter int SECT_SH   = 20,
   parameter int SUPER_SH  = 24,
   parameter int SUPER_BIT = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [ADDR_W-1:0] tbl_base,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [ADDR_W-1:0] mem_rd_data,
   output logic              done,
   output logic [ADDR_W-1:0] done_pa,
   output logic [1:0]        done_size,
   output logic              done_fault
);
   localparam int TBL_ALIGN = L1_IDX_W + 2;
   localparam int L2_ALIGN  = L2_IDX_W + 2;

   if (SECT_SH + L1_IDX_W != ADDR_W) begin : g_bad_l1
      $error("first-level index must cover the top address bits");
   end
   if (SECT_SH - SMALL_SH != L2_IDX_W) begin : g_bad_l2
      $error("second-level index must span the 1 MB to 4 KB bits");
   end
   if (!(SMALL_SH < LARGE_SH && LARGE_SH < SECT_SH && SECT_SH < SUPER_SH && SUPER_SH < ADDR_W)) begin : g_bad_order
      $error("page size shifts must be strictly increasing");
   end
   if (SUPER_BIT < 2 || SUPER_BIT >= SECT_SH) begin : g_bad_flag
      $error("16 MB flag must lie between the type field and the frame bits");
   end

   walk_state_e       state_q;
   logic              rd_en_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] pa_q;
   pg_size_e          size_q;
   logic              fault_q;
   logic [1:0]        rd_cnt_q;

   logic              l1_is_table, l1_fault, l2_fault;
   logic [ADDR_W-1:0] l1_pa, l2_pa, l2_addr;
   pg_size_e          l1_size, l2_size;

   iopt_l1_decode #(
      .ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .SMALL_SH(SMALL_SH),
      .SECT_SH(SECT_SH), .SUPER_SH(SUPER_SH), .SUPER_BIT(SUPER_BIT)
   ) u_l1 (
      .desc(mem_rd_data), .va(va_q), .is_table(l1_is_table),
      .leaf_fault(l1_fault), .leaf_pa(l1_pa), .leaf_size(l1_size),
      .l2_addr(l2_addr)
   );

   iopt_l2_decode #(
      .ADDR_W(ADDR_W), .SMALL_SH(SMALL_SH), .LARGE_SH(LARGE_SH)
   ) u_l2 (
      .desc(mem_rd_data), .va(va_q), .leaf_fault(l2_fault),
      .leaf_pa(l2_pa), .leaf_size(l2_size)
   );

   logic [ADDR_W-1:0] l1_addr;
   assign l1_addr = {tbl_base[ADDR_W-1:TBL_ALIGN], req_va[ADDR_W-1:SECT_SH], 2'b00};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         rd_en_q   <= 1'b0;
         rd_addr_q <= '0;
         va_q      <= '0;
         pa_q      <= '0;
         size_q    <= PG_4K;
         fault_q   <= 1'b0;
         rd_cnt_q  <= '0;
      end else begin
         rd_en_q <= 1'b0;
         if (rd_en_q) rd_cnt_q <= rd_cnt_q + 2'd1;
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  va_q      <= req_va;
                  rd_addr_q <= l1_addr;
                  rd_en_q   <= 1'b1;
                  rd_cnt_q  <= '0;
                  state_q   <= S_WAIT1;
               end
            end
            S_WAIT1: begin
               if (mem_rd_valid) begin
                  if (l1_is_table) begin
                     rd_addr_q <= l2_addr;
                     rd_en_q   <= 1'b1;
                     state_q   <= S_WAIT2;
                  end else begin
                     pa_q    <= l1_pa;
                     size_q  <= l1_size;
                     fault_q <= l1_fault;
                     state_q <= S_RESP;
                  end
               end
            end
            S_WAIT2: begin
               if (mem_rd_valid) begin
                  pa_q    <= l2_pa;
                  size_q  <= l2_size;
                  fault_q <= l2_fault;
                  state_q <= S_RESP;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == S_IDLE);
   assign mem_rd_en   = rd_en_q;
   assign mem_rd_addr = rd_addr_q;
   assign done        = (state_q == S_RESP);
   assign done_pa     = pa_q;
   assign done_size   = size_q;
   assign done_fault  = fault_q;

   assert_l1_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_rd_en
         && mem_rd_addr[ADDR_W-1:TBL_ALIGN] == $past(tbl_base[ADDR_W-1:TBL_ALIGN])
         && mem_rd_addr[TBL_ALIGN-1:2] == $past(req_va[ADDR_W-1:SECT_SH])
         && mem_rd_addr[1:0] == 2'b00));

   assert_l2_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT1 && mem_rd_valid && mem_rd_data[1:0] == 2'b01) |=> (mem_rd_en
         && mem_rd_addr[ADDR_W-1:L2_ALIGN] == $past(mem_rd_data[ADDR_W-1:L2_ALIGN])
         && mem_rd_addr[L2_ALIGN-1:2] == $past(va_q[SECT_SH-1:SMALL_SH])));

   assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_rd_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_cnt_q == 2'd1 || rd_cnt_q == 2'd2));

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_pa == '0 && done_size == 2'd0));

   assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_pa[SMALL_SH-1:0] == va_q[SMALL_SH-1:0]));

endmodule

// File: tb/tb_iopt_walker.sv
`timescale 1ns/1ps
module tb_iopt_walker;

   localparam int unsigned TBL = 32'h0001_C000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic [31:0] tbl_base = TBL;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        done;
   logic [31:0] done_pa;
   logic [1:0]  done_size;
   logic        done_fault;

   always #2 clk = ~clk;

   iopt_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .tbl_base(tbl_base), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .done(done), .done_pa(done_pa),
      .done_size(done_size), .done_fault(done_fault)
   );

   int checks = 0;
   int fails  = 0;
   int lat    = 1;
   int n_done = 0;
   bit mon_on = 0;
   string cur_tag = "R3";

   logic [31:0] mem [logic [31:0]];

   function automatic int unsigned rdm(int unsigned a);
      if (mem.exists(a)) return mem[a];
      return 0;
   endfunction

   // behavioural reference walk
   task automatic ref_walk(input int unsigned va, output int unsigned pa, output int sz,
                           output bit flt, output int nr, output int unsigned a2);
      int unsigned d1, d2;
      d1 = rdm(TBL - TBL % 16384 + (va / 32'h0010_0000) * 4);
      nr = 1; pa = 0; sz = 0; flt = 1; a2 = 0;
      if (d1 % 4 == 2) begin
         flt = 0;
         if ((d1 / 32'h0004_0000) % 2 == 1) begin
            sz = 3; pa = d1 - d1 % 32'h0100_0000 + va % 32'h0100_0000;
         end else begin
            sz = 2; pa = d1 - d1 % 32'h0010_0000 + va % 32'h0010_0000;
         end
      end else if (d1 % 4 == 1) begin
         nr = 2;
         a2 = d1 - d1 % 1024 + ((va / 4096) % 256) * 4;
         d2 = rdm(a2);
         if (d2 % 4 >= 2) begin
            flt = 0; sz = 0; pa = d2 - d2 % 4096 + va % 4096;
         end else if (d2 % 4 == 1) begin
            flt = 0; sz = 1; pa = d2 - d2 % 65536 + va % 65536;
         end
      end
   endtask

   // memory responder: drives at negedge
   initial begin
      int pend = 0;
      int unsigned paddr = 0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = rdm(paddr);
            end
         end
         if (mem_rd_en) begin
            paddr = mem_rd_addr;
            pend  = lat;
         end
      end
   end

   // cycle-by-cycle reference model and comparison
   initial begin
      bit busy = 0, exp_rd = 0, exp_done = 0, acc, nxt_rd, nxt_done;
      int unsigned exp_addr = 0, nxt_addr, r_pa = 0, r_a2 = 0;
      int r_sz = 0, r_nr = 0, rcnt = 0;
      bit r_flt = 0;
      forever begin
         @(negedge clk); #1;
         if (mon_on) begin
            checks++;
            if (req_ready !== !busy) begin
               fails++; $display("FAIL R10 req_ready act=%b exp=%b", req_ready, !busy);
            end
            if (mem_rd_en || exp_rd) begin
               checks++;
               if (mem_rd_en !== exp_rd || mem_rd_addr !== exp_addr) begin
                  fails++;
                  $display("FAIL %s read en/addr act=%b/%h exp=%b/%h",
                           (rcnt == 0) ? "R2" : "R5", mem_rd_en, mem_rd_addr, exp_rd, exp_addr);
               end
            end
            if (done || exp_done) begin
               checks++;
               if (done !== exp_done || done_pa !== r_pa || done_size !== 2'(r_sz)
                   || done_fault !== r_flt) begin
                  fails++;
                  $display("FAIL %s done/pa/size/fault act=%b/%h/%0d/%b exp=%b/%h/%0d/%b",
                           cur_tag, done, done_pa, done_size, done_fault,
                           exp_done, r_pa, r_sz, r_flt);
               end
               if (done) n_done++;
            end
            nxt_rd = 0; nxt_done = 0; nxt_addr = 0;
            acc = req_valid && !busy;
            if (exp_done) busy = 0;
            if (acc) begin
               busy = 1; rcnt = 0;
               ref_walk(req_va, r_pa, r_sz, r_flt, r_nr, r_a2);
               nxt_rd = 1;
               nxt_addr = TBL - TBL % 16384 + (req_va / 32'h0010_0000) * 4;
            end else if (mem_rd_valid && busy) begin
               rcnt++;
               if (rcnt == r_nr) nxt_done = 1;
               else begin nxt_rd = 1; nxt_addr = r_a2; end
            end
            exp_rd = nxt_rd; exp_addr = nxt_addr; exp_done = nxt_done;
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   task automatic go(input logic [31:0] va, input int l, input string tag);
      int target;
      lat = l; cur_tag = tag;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_va = va;
      target = n_done + 1;
      @(negedge clk);
      req_va = ~va;            // ignored while busy (R10)
      @(negedge clk);
      req_valid = 1'b0;
      wait (n_done >= target);
   endtask

   initial begin
      // table contents
      mem[TBL + 32'h123 * 4] = 32'h8760_0C12;                   // 1 MB
      for (int i = 0; i < 16; i++) mem[TBL + (32'h200 + i) * 4] = 32'h9A04_0002; // 16 MB
      mem[TBL + 32'h300 * 4] = 32'h0004_0401;                   // table at 0x40400
      mem[32'h0004_0400 + 32'h56 * 4] = 32'h7777_7002;          // 4 KB, type 10
      mem[32'h0004_0400 + 32'h57 * 4] = 32'h6666_6003;          // 4 KB, type 11
      for (int i = 0; i < 16; i++) mem[32'h0004_0400 + (32'h60 + i) * 4] = 32'h5555_0001; // 64 KB
      mem[TBL + 32'h500 * 4] = 32'h1234_5673;                   // reserved type
      mem[TBL + 32'h501 * 4] = 32'hFFFF_FFFC;                   // type 00, non-zero

      repeat (3) @(negedge clk);
      checks++;
      if (req_ready !== 1'b1 || done !== 1'b0 || mem_rd_en !== 1'b0) begin
         fails++; $display("FAIL R1 in reset ready/done/rd act=%b/%b/%b exp=1/0/0",
                           req_ready, done, mem_rd_en);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (req_ready !== 1'b1 || done !== 1'b0 || mem_rd_en !== 1'b0) begin
         fails++; $display("FAIL R1 after reset ready/done/rd act=%b/%b/%b exp=1/0/0",
                           req_ready, done, mem_rd_en);
      end
      mon_on = 1;

      go(32'h1234_5678, 1, "R3");
      go(32'h123F_FFFF, 3, "R3");
      go(32'h2000_0000, 1, "R4");   // first copy
      go(32'h20FF_FFFF, 2, "R4");   // last copy
      go(32'h2073_1234, 4, "R4");
      go(32'h3005_6ABC, 1, "R6");
      go(32'h3005_7FFF, 3, "R6");
      go(32'h3006_0000, 2, "R7");   // first copy
      go(32'h3006_FFFF, 1, "R7");   // last copy
      go(32'h3009_0000, 2, "R8");   // zero second-level word
      go(32'h4000_0000, 1, "R8");   // zero first-level word
      go(32'h5000_0010, 3, "R8");   // reserved first-level type
      go(32'h5011_0000, 1, "R8");   // type 00 with other bits set
      go(32'h3005_6000, 4, "R5");
      go(32'h1230_0000, 1, "R11");  // back to back
      go(32'h3006_1234, 1, "R9");
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule